// File: doc/BRIEF.md
# Two-Band Fan PWM Channel

This block drives a single fan-control output from a fixed 16 MHz fan clock. Software sets it through a write strobe, a two-bit register select and a data byte. The pulse period is a 7-bit divisor plus one, times 256 clocks. A band-select bit multiplies that by a further 256. This gives a fast band of roughly 488 Hz to 62.5 kHz and a slow band of roughly 2 Hz to 244 Hz. An 8-bit duty value sets the high time in steps of 1/256 of the period.

The duty and the divider are copied into working copies only at a period boundary, so a write never cuts a pulse short. While the channel is off, the working copies follow the registers and the counters sit at zero. Turning the channel on therefore starts a clean period at once. A mode flag can switch the channel to a steady-level mode. In that mode the pulse pin stays low and an 8-bit level output carries the duty value, which stands in for an analog stage. The channel index parameter picks which enable bit and which mode bit belong to this channel.

Top module: `fanpwm_channel`

## Requirements
- R1: The divider register (select 1) holds the divisor D in bits 6:0 and the band bit S in bit 7. One duty step lasts (D+1)·2^(8·S) clocks, and one period lasts 256 steps.
- R2: For a duty value d from 1 to 254 in pulse mode, the output is high for d steps of each period.
- R3: A duty value of 0xFF keeps the output high for the whole period, with no low cycle at the boundaries. A duty value of 0 keeps the output low.
- R4: A duty (select 0) or divider value written in the middle of a period does not change that period. It applies from the next period.
- R5: Setting this channel's enable bit (select 3, bit CHAN_IDX mod 8) starts a period from step zero. The output goes high on the second clock edge after the write edge, provided the duty value is nonzero.
- R6: Clearing the enable bit forces the output low from the second clock edge after the write, and the output stays low.
- R7: Config select 2, bit 4·(CHAN_IDX mod 2), set to 1 picks steady-level mode. In that mode the pulse output is low and dc_level equals the working duty value. In pulse mode, or while disabled, dc_level is 0.
- R8: After reset, the duty value is 0xFF, the divider is 0, the config byte is 0x44 (pulse mode) and the channel is disabled. pwm_out and dc_level are 0.
- R9: Writes that do not set this channel's enable bit leave the channel disabled. This includes enable-register writes that set only other channels' bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz fan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 duty, 1 divider, 2 config, 3 enable |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Pulse output, active high |
| dc_level | output | 8 | Steady-level value in level mode, else 0 |

## Verification
A fault in the step prescaler or the step counter shows up as a wrong high-cycle count inside one period. A period lasts 256 clocks in the fast band at divisor 0 and 65536 clocks in the slow band. A working copy that reloads at the wrong moment shows up as the first period after a mid-period write carrying the new duty value instead of the old one. The bench therefore counts high cycles over windows aligned to the first rising edge after enable. A stuck enable or mode bit shows at the pins within two clocks, as a low output or a wrong dc_level.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
  localparam int DUTY_W      = 8;
  localparam int DIV_W       = 7;
  localparam int BAND_SHIFT  = 8;
  localparam int SEL_W       = 2;
  localparam logic [7:0] CFG_RESET  = 8'h44;
  localparam logic [7:0] DUTY_RESET = 8'hFF;

  typedef enum logic [SEL_W-1:0] {
    SEL_DUTY = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_ENA  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             band_hi;
    logic [DIV_W-1:0] divisor;
  } div_word_t;
endpackage

// File: rtl/fanpwm_rst_sync.sv
module fanpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
  import fanpwm_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  output logic [DUTY_W-1:0] duty_live,
  output div_word_t         div_live,
  output logic              mode_dc,
  output logic              chan_en
);
  localparam int EN_BIT   = CHAN_IDX % 8;
  localparam int MODE_BIT = 4 * (CHAN_IDX % 2);

  logic [DUTY_W-1:0] duty_q, duty_d;
  div_word_t         div_q, div_d;
  logic              mode_q, mode_d;
  logic              en_q, en_d;

  always_comb begin
    duty_d = duty_q;
    div_d  = div_q;
    mode_d = mode_q;
    en_d   = en_q;
    if (wr_en) begin
      unique case (wr_addr)
        SEL_DUTY: duty_d = wr_data[DUTY_W-1:0];
        SEL_DIV:  div_d  = div_word_t'(wr_data);
        SEL_CFG:  mode_d = wr_data[MODE_BIT];
        SEL_ENA:  en_d   = wr_data[EN_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= DUTY_RESET;
      div_q  <= '0;
      mode_q <= CFG_RESET[MODE_BIT];
      en_q   <= 1'b0;
    end else begin
      duty_q <= duty_d;
      div_q  <= div_d;
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  assign duty_live = duty_q;
  assign div_live  = div_q;
  assign mode_dc   = mode_q;
  assign chan_en   = en_q;

  AST_ENABLE_ONLY_BY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != SEL_ENA) |=> $stable(chan_en)); // R9
endmodule

// File: rtl/fanpwm_timebase.sv
module fanpwm_timebase
  import fanpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DUTY_W-1:0] duty_live,
  input  div_word_t         div_live,
  output logic [DUTY_W-1:0] duty_work,
  output logic [DUTY_W-1:0] step_cnt,
  output logic              boundary
);
  localparam int PRE_W = DIV_W + 1 + BAND_SHIFT;
  localparam logic [DUTY_W-1:0] STEP_LAST = '1;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DUTY_W-1:0] step_q, step_d;
  logic [DUTY_W-1:0] duty_sh_q, duty_sh_d;
  div_word_t         div_sh_q, div_sh_d;
  logic [PRE_W-1:0]  step_len;
  logic              tick;
  logic              reload;

  always_comb begin
    step_len = {{(PRE_W-DIV_W){1'b0}}, div_sh_q.divisor} + PRE_W'(1);
    if (div_sh_q.band_hi) step_len = step_len << BAND_SHIFT;
  end

  assign tick     = (pre_q == step_len - PRE_W'(1));
  assign boundary = run && tick && (step_q == STEP_LAST);
  assign reload   = !run || boundary;

  always_comb begin
    pre_d     = pre_q;
    step_d    = step_q;
    duty_sh_d = duty_sh_q;
    div_sh_d  = div_sh_q;
    if (!run) begin
      pre_d  = '0;
      step_d = '0;
    end else if (tick) begin
      pre_d  = '0;
      step_d = step_q + DUTY_W'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
    if (reload) begin
      duty_sh_d = duty_live;
      div_sh_d  = div_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      step_q    <= '0;
      duty_sh_q <= DUTY_RESET;
      div_sh_q  <= '0;
    end else begin
      pre_q     <= pre_d;
      step_q    <= step_d;
      duty_sh_q <= duty_sh_d;
      div_sh_q  <= div_sh_d;
    end
  end

  assign duty_work = duty_sh_q;
  assign step_cnt  = step_q;

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < step_len); // R1
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (step_q == $past(step_q) + DUTY_W'(1))); // R1
  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> ($stable(duty_sh_q) && $stable(div_sh_q))); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (step_q == '0 && pre_q == '0)); // R5
endmodule

// File: rtl/fanpwm_outstage.sv
module fanpwm_outstage
  import fanpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mode_dc,
  input  logic [DUTY_W-1:0] duty_work,
  input  logic [DUTY_W-1:0] step_cnt,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] dc_level
);
  localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

  logic              pulse_q, pulse_d;
  logic [DUTY_W-1:0] level_q, level_d;

  always_comb begin
    pulse_d = 1'b0;
    level_d = '0;
    if (run) begin
      if (mode_dc) level_d = duty_work;
      else         pulse_d = (duty_work == DUTY_FULL) || (step_cnt < duty_work);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      level_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      level_q <= level_d;
    end
  end

  assign pwm_out  = pulse_q;
  assign dc_level = level_q;

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm_out && dc_level == '0)); // R6
  AST_LEVEL_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dc |=> !pwm_out); // R7
  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_dc && duty_work == DUTY_FULL) |=> pwm_out); // R3
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_work == '0) |=> !pwm_out); // R3
endmodule

// File: rtl/fanpwm_channel.sv
module fanpwm_channel
  import fanpwm_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] dc_level
);
  logic              rst_int_n;
  logic [DUTY_W-1:0] duty_live;
  div_word_t         div_live;
  logic              mode_dc;
  logic              chan_en;
  logic [DUTY_W-1:0] duty_work;
  logic [DUTY_W-1:0] step_cnt;
  logic              boundary;

  fanpwm_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fanpwm_regs #(.CHAN_IDX(CHAN_IDX)) i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .duty_live (duty_live),
    .div_live  (div_live),
    .mode_dc   (mode_dc),
    .chan_en   (chan_en)
  );

  fanpwm_timebase i_timebase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (chan_en),
    .duty_live (duty_live),
    .div_live  (div_live),
    .duty_work (duty_work),
    .step_cnt  (step_cnt),
    .boundary  (boundary)
  );

  fanpwm_outstage i_outstage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (chan_en),
    .mode_dc   (mode_dc),
    .duty_work (duty_work),
    .step_cnt  (step_cnt),
    .pwm_out   (pwm_out),
    .dc_level  (dc_level)
  );

  AST_RELOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    boundary |=> (step_cnt == '0)); // R4
endmodule

// File: tb/test_fanpwm_channel.sv
module test_fanpwm_channel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_out;
  logic [7:0] dc_level;

  int errors = 0;
  int checks = 0;

  fanpwm_channel i_fanpwm_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwm_out  (pwm_out),
    .dc_level (dc_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  // Waits for the first high sample after enable, then counts n samples from it.
  // Optionally issues one register write at sample index 10.
  task automatic aligned_count(input int n, input bit do_wr, input logic [1:0] a,
                               input logic [7:0] d, output int h);
    int guard;
    guard = 0;
    while (!pwm_out && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
    h = pwm_out ? 1 : 0;
    for (int i = 1; i < n; i++) begin
      if (do_wr && i == 10) begin
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      if (pwm_out) h++;
    end
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check_eq("R8 pwm_out after reset", int'(pwm_out), 0);
    check_eq("R8 dc_level after reset", int'(dc_level), 0);
  endtask

  task automatic t_default_full;
    int h;
    reg_write(2'd3, 8'h01);
    repeat (20) @(negedge clk);
    count_high(600, h);
    check_eq("R8 R3 default duty full-on highs", h, 600);
  endtask

  task automatic t_zero;
    int h;
    reg_write(2'd0, 8'h00);
    repeat (300) @(negedge clk);
    count_high(512, h);
    check_eq("R3 duty zero highs", h, 0);
  endtask

  task automatic t_deferred_duty;
    int h;
    reg_write(2'd3, 8'h00);
    reg_write(2'd0, 8'd64);
    reg_write(2'd1, 8'h00);
    reg_write(2'd3, 8'h01);
    aligned_count(256, 1'b1, 2'd0, 8'd200, h);
    check_eq("R4 R5 first period keeps old duty", h, 64);
    count_high(256, h);
    check_eq("R2 R4 next period uses new duty", h, 200);
  endtask

  task automatic t_divider;
    int h;
    reg_write(2'd3, 8'h00);
    reg_write(2'd0, 8'd64);
    reg_write(2'd1, 8'h00);
    reg_write(2'd3, 8'h01);
    aligned_count(256, 1'b1, 2'd1, 8'h01, h);
    check_eq("R4 divider change deferred", h, 64);
    count_high(512, h);
    check_eq("R1 divisor 1 doubles step length", h, 128);
    reg_write(2'd3, 8'h00);
    reg_write(2'd0, 8'd128);
    reg_write(2'd1, 8'h80);
    reg_write(2'd3, 8'h01);
    aligned_count(65536, 1'b0, 2'd0, 8'd0, h);
    check_eq("R1 slow band half duty", h, 32768);
  endtask

  task automatic t_disable;
    int h;
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, 8'd200);
    repeat (600) @(negedge clk);
    reg_write(2'd3, 8'h00);
    @(negedge clk);
    count_high(300, h);
    check_eq("R6 disabled output highs", h, 0);
  endtask

  task automatic t_other_bits;
    int h;
    reg_write(2'd0, 8'hFF);
    reg_write(2'd3, 8'hFE);
    reg_write(2'd2, 8'h44);
    count_high(300, h);
    check_eq("R9 foreign enable bits ignored", h, 0);
  endtask

  task automatic t_level_mode;
    int h;
    reg_write(2'd0, 8'h5A);
    reg_write(2'd2, 8'h45);
    reg_write(2'd3, 8'h01);
    repeat (300) @(negedge clk);
    count_high(300, h);
    check_eq("R7 level mode pulse highs", h, 0);
    check_eq("R7 level mode dc_level", int'(dc_level), 90);
    reg_write(2'd2, 8'h44);
    repeat (300) @(negedge clk);
    check_eq("R7 pulse mode dc_level", int'(dc_level), 0);
    count_high(256, h);
    check_eq("R2 R7 pulse mode highs", h, 90);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_full();
    t_zero();
    t_deferred_duty();
    t_divider();
    t_disable();
    t_other_bits();
    t_level_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule